// File: doc/BRIEF.md
# Prioritized Interrupt Pending Selector

This block decides, once per clock, whether a hart should take a local interrupt and which source to take. It receives the raw pending vector, the per-source enable vector, a mask that marks each source as handled by the supervisor level instead of the machine level, the current privilege level, and the machine and supervisor global enable bits. Each source passes through the global enable of the level that would handle it. That gate is always open when the hart runs at a lower privilege than the handling level. It is always closed when the hart runs at a higher privilege than the handling level, and it follows the global enable bit when the hart runs at exactly that level.

Of the sources that survive the gates, the one with the lowest index wins. The result is registered once, so the trap-entry logic downstream sees a flop output and no long combinational path. All pins are plain control and status signals. The inputs are sampled on every rising edge and there is no handshake or back-pressure.

Top module: `irq_pick`

## Requirements
- R1: While the active-low reset is asserted, and on the first clock after it, take_o is 0 and cause_o is 0.
- R2: A source is a candidate only if its bit is set in both pend_i and en_i. A pending source whose enable bit is clear is never taken.
- R3: A source whose deleg_i bit is 0 is machine-handled. It is eligible at privilege U (2'd0) or S (2'd1) regardless of mgie_i, and at privilege M (2'd3) only when mgie_i is 1.
- R4: A source whose deleg_i bit is 1 is supervisor-handled. It is eligible at privilege U regardless of sgie_i, at privilege S only when sgie_i is 1, and never at privilege M.
- R5: The eligible set is the union of the machine-handled candidates that pass the R3 gate and the supervisor-handled candidates that pass the R4 gate. Both kinds can appear in the same cycle and are judged independently.
- R6: When the eligible set is non-zero, take_o is 1 and cause_o is the index of the lowest set bit of the eligible set (bit 0 has the highest priority).
- R7: When the eligible set is zero, take_o is 0 and cause_o is 0.
- R8: take_o and cause_o reflect the inputs sampled at the previous rising edge. A change on the inputs does not reach the outputs before the next rising edge.
- R9: The privilege encoding 2'd2 lies between S and M. At that encoding the machine gate is open regardless of mgie_i, and the supervisor gate is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 16 | Pending interrupt bits, one per source |
| en_i | input | 16 | Per-source enable bits |
| deleg_i | input | 16 | 1 = source handled at supervisor level, 0 = machine level |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| mgie_i | input | 1 | Machine global interrupt enable |
| sgie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | 4 | Index of the selected source |

## Verification
The bench targets the privilege and delegation corners. These are a machine-handled source at S or U with mgie_i clear, a supervisor-handled source at U with sgie_i clear, and a supervisor-handled source at M with every enable set. A design that compared privilege the wrong way, or gated by the running level instead of the handling level, would wrongly mask or wrongly take these. Mixed vectors, where a low delegated bit is blocked while a higher machine bit passes, would show an encoder that picks from the candidate set instead of the eligible set. All-ones vectors and a lone bit 15 would show a priority order that is reversed or cut short. A check between edges would show an output that leaks through without the register.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

  localparam int unsigned SRC_COUNT = 16;
  localparam int unsigned CAUSE_W   = $clog2(SRC_COUNT);

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_MID   = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  typedef struct packed {
    logic                 take;
    logic [CAUSE_W-1:0]   cause;
  } pick_t;

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_pick_pkg::*;
#(
  parameter int unsigned N = SRC_COUNT
) (
  input  logic [N-1:0] cand_i,
  input  logic [N-1:0] deleg_i,
  input  logic [1:0]   priv_i,
  input  logic         mgie_i,
  input  logic         sgie_i,
  output logic [N-1:0] elig_o
);

  logic m_open;
  logic s_open;

  always_comb begin
    m_open = (priv_i < 2'(LVL_MACH)) ||
             ((priv_i == 2'(LVL_MACH)) && mgie_i);
    s_open = (priv_i < 2'(LVL_SUPER)) ||
             ((priv_i == 2'(LVL_SUPER)) && sgie_i);
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    assign elig_o[g] = cand_i[g] & (deleg_i[g] ? s_open : m_open);
  end

endmodule

// File: rtl/irq_low_first.sv
module irq_low_first #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pick_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] pend_i,
  input  logic [15:0] en_i,
  input  logic [15:0] deleg_i,
  input  logic [1:0]  priv_i,
  input  logic        mgie_i,
  input  logic        sgie_i,
  output logic        take_o,
  output logic [3:0]  cause_o
);

  logic [SRC_COUNT-1:0] cand;
  logic [SRC_COUNT-1:0] elig;
  logic                 hit;
  logic [CAUSE_W-1:0]   hit_idx;
  pick_t                pick_q;

  assign cand = pend_i & en_i;

  irq_level_gate #(.N(SRC_COUNT)) u_gate (
    .cand_i (cand),
    .deleg_i(deleg_i),
    .priv_i (priv_i),
    .mgie_i (mgie_i),
    .sgie_i (sgie_i),
    .elig_o (elig)
  );

  irq_low_first #(.N(SRC_COUNT)) u_enc (
    .vec_i(elig),
    .any_o(hit),
    .idx_o(hit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_q <= '0;
    end else begin
      pick_q.take  <= hit;
      pick_q.cause <= hit ? hit_idx : '0;
    end
  end

  assign take_o  = pick_q.take;
  assign cause_o = pick_q.cause;

  AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> cause_o == 4'd0); // R7

  AST_TAKE_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((($past(pend_i & en_i)) >> cause_o) & 16'd1) == 16'd1); // R2

  AST_NO_LOWER_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(pend_i & en_i & ~deleg_i) | ($past(pend_i & en_i) & 16'd0))
                & ((16'd1 << cause_o) - 16'd1) & {16{$past(priv_i) != 2'd3}}) == 16'd0); // R6

  AST_MACH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(priv_i) == 2'd3 && !$past(mgie_i)) |-> !take_o); // R3

  AST_SUPER_AT_MACH: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(priv_i) == 2'd3) |-> (($past(deleg_i) >> cause_o) & 16'd1) == 16'd0); // R4

  AST_SUPER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && $past(priv_i) == 2'd1 && !$past(sgie_i))
      |-> (($past(deleg_i) >> cause_o) & 16'd1) == 16'd0); // R4

  AST_HOLD_NO_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_i & en_i) == 16'd0) |-> !take_o); // R8

endmodule

// File: tb/irq_pick_test.sv
module irq_pick_test;

  typedef struct packed {
    logic [15:0] pend;
    logic [15:0] en;
    logic [15:0] deleg;
    logic [1:0]  priv;
    logic        mgie;
    logic        sgie;
    logic        xtake;
    logic [3:0]  xcause;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd7},
    '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0},
    '{16'h0080, 16'h0080, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h0080, 16'h0080, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7},
    '{16'h0022, 16'h0022, 16'h0022, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0},
    '{16'h0022, 16'h0022, 16'h0022, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1},
    '{16'h0022, 16'h0022, 16'h0022, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1},
    '{16'h0022, 16'h0022, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0},
    '{16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0},
    '{16'h0F00, 16'h0A00, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd9},
    '{16'h0202, 16'h0202, 16'h0002, 2'd3, 1'b1, 1'b1, 1'b1, 4'd9},
    '{16'h0202, 16'h0202, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 4'd9},
    '{16'h0202, 16'h0202, 16'h0002, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1},
    '{16'h8000, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd15},
    '{16'hFFFF, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd0},
    '{16'h000C, 16'h000C, 16'h0004, 2'd2, 1'b0, 1'b1, 1'b1, 4'd3},
    '{16'h000C, 16'h000C, 16'hFFFF, 2'd2, 1'b1, 1'b1, 1'b0, 4'd0}
  };

  localparam string TAGS [NV] = '{
    "R3", "R3", "R3", "R3", "R4", "R4", "R4", "R4", "R2",
    "R2", "R5", "R5", "R6", "R6", "R6", "R9", "R9"
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pend_i = '0;
  logic [15:0] en_i = '0;
  logic [15:0] deleg_i = '0;
  logic [1:0]  priv_i = '0;
  logic        mgie_i = 1'b0;
  logic        sgie_i = 1'b0;
  logic        take_o;
  logic [3:0]  cause_o;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_pick uut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
    .deleg_i(deleg_i), .priv_i(priv_i), .mgie_i(mgie_i), .sgie_i(sgie_i),
    .take_o(take_o), .cause_o(cause_o)
  );

  task automatic check(input string tag, input logic t, input logic [3:0] c,
                       input logic xt, input logic [3:0] xc);
    n_run++;
    if (t !== xt || c !== xc) begin
      n_bad++;
      $display("FAIL %s: take=%0b cause=%0d, expected take=%0b cause=%0d",
               tag, t, c, xt, xc);
    end
  endtask

  task automatic drive(input vec_t v);
    pend_i  = v.pend;
    en_i    = v.en;
    deleg_i = v.deleg;
    priv_i  = v.priv;
    mgie_i  = v.mgie;
    sgie_i  = v.sgie;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    drive(VECS[14]);
    #5;
    check("R1 in reset", take_o, cause_o, 1'b0, 4'd0);
    repeat (2) @(negedge clk);
    check("R1 held reset", take_o, cause_o, 1'b0, 4'd0);
    rst_n = 1'b1;
    drive(VECS[8]);
    @(negedge clk);
    check("R1 first clock", take_o, cause_o, 1'b0, 4'd0);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      check(TAGS[k], take_o, cause_o, VECS[k].xtake, VECS[k].xcause);
    end

    // R8: output stays on the old value until the next rising edge
    drive(VECS[0]);
    @(negedge clk);
    check("R8 settled", take_o, cause_o, 1'b1, 4'd7);
    drive(VECS[13]);
    #5;
    check("R8 before edge", take_o, cause_o, 1'b1, 4'd7);
    @(negedge clk);
    check("R8 after edge", take_o, cause_o, 1'b1, 4'd15);

    // R7: clearing all enables drops the request and zeroes the cause
    en_i = 16'h0000;
    @(negedge clk);
    check("R7 no eligible", take_o, cause_o, 1'b0, 4'd0);

    // R1: reset while a request is active
    drive(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 async reset", take_o, cause_o, 1'b0, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule